// File: doc/BRIEF.md
# Serial-Load Staggered Channel Driver Control

This block is the digital control path of a sixteen-channel, serially loaded on/off driver. A serial data bit is taken in on each rising edge of a slow shift clock. The bits move along a chain of stages, and the last stage is driven out on a serial output so that several blocks can be chained. A level-sensitive strobe copies the chain into a holding stage. An active-low output enable gates the held bits onto the channel outputs. Each channel output is a logic on/off request for an external current sink.

All timing is taken from a fast system clock. The shift clock, data, strobe and enable inputs pass through two-flop synchronizers, and a shift takes place when a rising edge of the synchronized shift clock is detected. Each channel then repeats its gated request after a delay of its index times a fixed step, counted in system-clock cycles. Channel 0 has no delay. Because of this stagger, the channels never switch together. The same stagger applies to turn-on and turn-off, and every pulse keeps its full width.

Top module: `sled_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the shift chain and the holding stage and turns every channel off. After reset, the serial output is 0 and all channel outputs are 0, even when the enable is asserted.
- R2: Each detected rising edge of the shift clock moves the chain one place. The new bit enters stage 0, and stage k moves to stage k+1. While the shift clock stays high, or stays low, the chain does not move, whatever the data input does.
- R3: The serial output shows stage NUM_CH-1. After NUM_CH shifts it carries the first bit of those NUM_CH bits, so a word sent most-significant bit first ends with stage k holding bit k.
- R4: While the strobe is high, the holding stage follows the chain. While the strobe is low, the holding stage keeps its value, and shifting has no effect on the channel outputs.
- R5: With the enable (active low) high, every channel is off. With it low, channel k is on when held bit k is 1 and off when that bit is 0.
- R6: Channel k changes exactly k*STEP_CYC system cycles after channel 0, for turn-on and for turn-off alike.
- R7: A change of the enable input that lasts W cycles gives every channel a pulse of exactly W cycles. A channel still makes its pulse after the enable has already returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Shift clock, asynchronous and slow |
| sdata_in | input | 1 | Serial data input |
| strobe_in | input | 1 | Holding-stage strobe; high is transparent |
| oe_n_in | input | 1 | Active-low output enable |
| sdata_out | output | 1 | Serial output, last chain stage |
| ch_on | output | NUM_CH | Per-channel on request, staggered |

## Verification
The checker tests four things on every cycle. A detected shift-clock edge moves the chain by exactly one place, and the chain stays still when there is no edge. The holding stage follows the chain while the strobe is high and stays stable while it is low. A high enable clears the gated request one cycle later. The other behaviours can only be shown by the bench's scenarios: the serial-output sequence over a full word, the per-channel delay of k times the step in both directions, full-width pulses that outlive the enable, and the state after reset.

// File: rtl/sled_pkg.sv
package sled_pkg;
    localparam int unsigned DEF_CH   = 16;
    localparam int unsigned DEF_STEP = 1;
    localparam int unsigned DEF_SYNC = 2;

    // delay, in system cycles, applied to a channel index
    function automatic int unsigned lag_cycles(input int unsigned idx, input int unsigned step);
        return idx * step;
    endfunction
endpackage

// File: rtl/sled_sync.sv
module sled_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = sled_pkg::DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/sled_core.sv
module sled_core #(
    parameter int unsigned NUM_CH = sled_pkg::DEF_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              strb_s,
    input  logic              oen_s,
    output logic              shift_rise,
    output logic [NUM_CH-1:0] shift_q,
    output logic [NUM_CH-1:0] latch_q,
    output logic [NUM_CH-1:0] gate_q
);
    typedef struct packed {
        logic [NUM_CH-1:0] chain;
        logic [NUM_CH-1:0] hold;
        logic [NUM_CH-1:0] gate;
        logic              sclk_prev;
    } core_t;

    core_t st_d, st_q;

    assign shift_rise = sclk_s & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        if (shift_rise) st_d.chain = {st_q.chain[NUM_CH-2:0], sdat_s};
        if (strb_s)     st_d.hold  = st_q.chain;
        st_d.gate      = oen_s ? '0 : st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shift_q = st_q.chain;
    assign latch_q = st_q.hold;
    assign gate_q  = st_q.gate;
endmodule

// File: rtl/sled_dly.sv
module sled_dly #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    if (DEPTH == 1) begin : g_one
        logic bit_d, bit_q;
        always_comb bit_d = din;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= bit_d;
        end
        assign dout = bit_q;
    end else begin : g_line
        logic [DEPTH-1:0] line_d, line_q;
        always_comb line_d = {line_q[DEPTH-2:0], din};
        always_ff @(posedge clk) begin
            if (rst) line_q <= '0;
            else     line_q <= line_d;
        end
        assign dout = line_q[DEPTH-1];
    end
endmodule

// File: rtl/sled_stagger.sv
module sled_stagger #(
    parameter int unsigned NUM_CH   = sled_pkg::DEF_CH,
    parameter int unsigned STEP_CYC = sled_pkg::DEF_STEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] ch_on
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int unsigned LAG = sled_pkg::lag_cycles(n, STEP_CYC);
        if (LAG == 0) begin : g_direct
            assign ch_on[n] = req[n];
        end else begin : g_delayed
            sled_dly #(.DEPTH(LAG)) u_dly (
                .clk  (clk),
                .rst  (rst),
                .din  (req[n]),
                .dout (ch_on[n])
            );
        end
    end
endmodule

// File: rtl/sled_ctrl.sv
module sled_ctrl #(
    parameter int unsigned NUM_CH      = sled_pkg::DEF_CH,
    parameter int unsigned STEP_CYC    = sled_pkg::DEF_STEP,
    parameter int unsigned SYNC_STAGES = sled_pkg::DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              strobe_in,
    input  logic              oe_n_in,
    output logic              sdata_out,
    output logic [NUM_CH-1:0] ch_on
);
    localparam int unsigned NUM_IN = 4;

    logic [NUM_IN-1:0] raw_in, syn_out;
    logic              sclk_s, sdat_s, strb_s, oen_s;
    logic              shift_rise;
    logic [NUM_CH-1:0] shift_q, latch_q, gate_q;

    assign raw_in = {oe_n_in, strobe_in, sdata_in, sclk_in};

    sled_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (syn_out)
    );

    assign {oen_s, strb_s, sdat_s, sclk_s} = syn_out;

    sled_core #(.NUM_CH(NUM_CH)) u_core (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sclk_s),
        .sdat_s     (sdat_s),
        .strb_s     (strb_s),
        .oen_s      (oen_s),
        .shift_rise (shift_rise),
        .shift_q    (shift_q),
        .latch_q    (latch_q),
        .gate_q     (gate_q)
    );

    sled_stagger #(.NUM_CH(NUM_CH), .STEP_CYC(STEP_CYC)) u_stag (
        .clk   (clk),
        .rst   (rst),
        .req   (gate_q),
        .ch_on (ch_on)
    );

    assign sdata_out = shift_q[NUM_CH-1];
endmodule

// File: rtl/sled_ctrl_chk.sv
module sled_ctrl_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         shift_rise,
    input logic         sdat_s,
    input logic         strb_s,
    input logic         oen_s,
    input logic [N-1:0] shift_q,
    input logic [N-1:0] latch_q,
    input logic [N-1:0] gate_q
);
    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        shift_rise |=> (shift_q[0] == $past(sdat_s)) && (shift_q[N-1:1] == $past(shift_q[N-2:0])));

    // R2
    no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_rise |=> $stable(shift_q));

    // R4
    latch_pass_chk: assert property (@(posedge clk) disable iff (rst)
        strb_s |=> latch_q == $past(shift_q));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !strb_s |=> $stable(latch_q));

    // R5
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        oen_s |=> gate_q == '0);
endmodule

bind sled_ctrl sled_ctrl_chk #(.N(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_rise (shift_rise),
    .sdat_s     (sdat_s),
    .strb_s     (strb_s),
    .oen_s      (oen_s),
    .shift_q    (shift_q),
    .latch_q    (latch_q),
    .gate_q     (gate_q)
);

// File: tb/tb_sled_ctrl.sv
module tb_sled_ctrl;
    localparam int N    = 16;
    localparam int STEP = 2;
    localparam int SETTLE = N * STEP + 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0, sdat = 1'b0, strb = 1'b0, oen = 1'b1;
    logic         sout;
    logic [N-1:0] ch;

    logic [N-1:0] model = '0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sled_ctrl #(.NUM_CH(N), .STEP_CYC(STEP), .SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk),
        .sdata_in  (sdat),
        .strobe_in (strb),
        .oe_n_in   (oen),
        .sdata_out (sout),
        .ch_on     (ch)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    function automatic logic [N-1:0] gated(input logic [N-1:0] held, input logic en_n);
        return en_n ? '0 : held;
    endfunction

    task automatic push(input logic b);
        sdat = b;
        idle(4);
        sclk = 1'b1;
        idle(6);
        model = {model[N-2:0], b};
        check(sout === model[N-1], "R3 serial out", 32'(sout), 32'(model[N-1]));
        sclk = 1'b0;
        idle(4);
    endtask

    task automatic load(input logic [N-1:0] pat);
        for (int i = N - 1; i >= 0; i--) push(pat[i]);
        check(model === pat, "R3 word placement", 32'(model), 32'(pat));
    endtask

    task automatic pulse_strobe();
        strb = 1'b1;
        idle(5);
        strb = 1'b0;
    endtask

    initial begin
        if (!done) begin
            repeat (200000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] held, pat;
        logic         en_pick;
        int           t_on [N];
        int           cnt [N];
        void'($urandom(32'd1234));

        idle(5);
        rst = 1'b0;
        idle(2);
        // R1: state after reset
        check(sout === 1'b0, "R1 sdata_out", 32'(sout), 0);
        check(ch === '0, "R1 channels", 32'(ch), 0);
        oen = 1'b0;
        idle(SETTLE);
        check(ch === '0, "R1 held cleared", 32'(ch), 0);

        // R3 / R4: load with strobe low, channels stay off
        load(16'hA5C3);
        idle(SETTLE);
        check(ch === '0, "R4 hold while shifting", 32'(ch), 0);

        // R2: shift clock held high, data toggling, no extra shift
        sdat = 1'b1;
        idle(4);
        sclk = 1'b1;
        idle(6);
        model = {model[N-2:0], 1'b1};
        for (int i = 0; i < 24; i++) begin
            sdat = ~sdat;
            idle(1);
        end
        check(sout === model[N-1], "R2 no shift while high", 32'(sout), 32'(model[N-1]));
        sclk = 1'b0;
        for (int i = 0; i < 24; i++) begin
            sdat = ~sdat;
            idle(1);
        end
        check(sout === model[N-1], "R2 no shift while low", 32'(sout), 32'(model[N-1]));

        // R4: transparent
        strb = 1'b1;
        idle(SETTLE);
        check(ch === model, "R4 transparent", 32'(ch), 32'(model));
        push(1'b0);
        idle(SETTLE);
        check(ch === model, "R4 transparent follows shift", 32'(ch), 32'(model));
        strb = 1'b0;
        idle(4);
        held = model;
        load(~held);
        idle(SETTLE);
        check(ch === held, "R4 holding", 32'(ch), 32'(held));
        pulse_strobe();
        idle(SETTLE);
        check(ch === model, "R4 new capture", 32'(ch), 32'(model));

        // R5: override
        oen = 1'b1;
        idle(SETTLE);
        check(ch === '0, "R5 enable high forces off", 32'(ch), 0);
        oen = 1'b0;
        idle(SETTLE);
        check(ch === model, "R5 enable low follows", 32'(ch), 32'(model));

        // R5 random patterns
        for (int k = 0; k < 12; k++) begin
            pat     = N'($urandom());
            en_pick = 1'($urandom());
            load(pat);
            pulse_strobe();
            oen = en_pick;
            idle(SETTLE);
            check(ch === gated(pat, en_pick), "R5 random", 32'(ch), 32'(gated(pat, en_pick)));
        end

        // R6: stagger on turn-on and turn-off
        oen = 1'b1;
        load('1);
        pulse_strobe();
        idle(SETTLE);
        for (int n = 0; n < N; n++) t_on[n] = -1;
        oen = 1'b0;
        for (int c = 0; c < SETTLE; c++) begin
            idle(1);
            for (int n = 0; n < N; n++) if (ch[n] && t_on[n] < 0) t_on[n] = c;
        end
        for (int n = 0; n < N; n++)
            check(t_on[n] - t_on[0] == n * STEP, "R6 turn-on lag", 32'(t_on[n] - t_on[0]), 32'(n * STEP));
        for (int n = 0; n < N; n++) t_on[n] = -1;
        oen = 1'b1;
        for (int c = 0; c < SETTLE; c++) begin
            idle(1);
            for (int n = 0; n < N; n++) if (!ch[n] && t_on[n] < 0) t_on[n] = c;
        end
        for (int n = 0; n < N; n++)
            check(t_on[n] - t_on[0] == n * STEP, "R6 turn-off lag", 32'(t_on[n] - t_on[0]), 32'(n * STEP));

        // R7: short enable pulse keeps its width on every channel
        for (int n = 0; n < N; n++) cnt[n] = 0;
        oen = 1'b0;
        for (int c = 0; c < SETTLE + 8; c++) begin
            @(negedge clk);
            if (c == 2) oen = 1'b1;
            for (int n = 0; n < N; n++) if (ch[n]) cnt[n]++;
        end
        for (int n = 0; n < N; n++)
            check(cnt[n] == 3, "R7 pulse width", 32'(cnt[n]), 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule